// File: doc/BRIEF.md
# Translation Lookaside Buffer with Access Permission Checks

This block is a small, fully associative translation cache for a 32-bit virtual address space split into 4 KB pages. Every lookup compares the virtual page number and the current process identifier against all stored entries in parallel. On a match, the stored frame number is joined to the untranslated 12-bit page offset to form the physical address.

Each entry carries a present flag, a write-allowed flag, a user-accessible flag, an accessed flag and a dirty flag. The block checks every access against these flags, not only the translation. It reports a hit, a miss, or a fault with a reason code. For each successful access it raises update requests for the accessed and dirty flags and records them in the entry itself.

Entries are loaded by an external page-table walker through a refill port. The refill goes to the lowest free slot, or to a round-robin victim when no slot is free. A flush input empties the whole buffer on a context switch. An ageing input clears every accessed flag at once.

Top module: `tlb_perm`

## Requirements
- R1: On a lookup that matches an entry and passes every check, `pa` equals the entry's frame number in bits 31:12, concatenated with bits 11:0 of `lk_vaddr`. `hit` is 1 and `fault` is 0.
- R2: An entry matches only when it is valid and both its page number and its process ID equal the lookup's. With no match, `miss` is 1 while `hit`, `fault`, `fault_code` and `pa` are all 0.
- R3: A hit on an entry whose present flag is 0 gives `fault`=1 and `fault_code`=1. This takes priority over every other reason.
- R4: On a present page, a user-mode access (`lk_user`=1) to an entry whose user flag is 0 gives `fault_code`=3. This takes priority over the write check.
- R5: On a present, permitted page, a write (`lk_write`=1) to an entry whose write-allowed flag is 0 gives `fault_code`=2. In every other case `fault_code`=0, and `fault` is 1 exactly when `fault_code` is nonzero.
- R6: A non-faulting hit raises `set_accessed`, and raises `set_dirty` when it is a write. Both flags are recorded in the entry and reported on later hits through `hit_accessed` and `hit_dirty`. A faulting access sets neither flag.
- R7: A cycle with `age_clear`=1 resets the accessed flag of every entry to 0.
- R8: `flush` invalidates every entry from the next cycle on and returns the round-robin victim pointer to slot 0. A flush wins over a refill in the same cycle.
- R9: A refill writes to the lowest-numbered invalid slot. When every slot is valid, it writes to the round-robin victim, which starts at slot 0 and advances by one (wrapping) on each such eviction. A refilled entry starts with its accessed and dirty flags at 0.
- R10: While `lk_valid` is 0, `hit`, `miss`, `fault`, `set_accessed` and `set_dirty` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| cur_pid | input | 4 | Process ID of the running process |
| fill_en | input | 1 | Load one entry |
| fill_vpn | input | 20 | Page number of the loaded entry |
| fill_pid | input | 4 | Process ID of the loaded entry |
| fill_pfn | input | 20 | Frame number of the loaded entry |
| fill_present | input | 1 | Present flag of the loaded entry |
| fill_writable | input | 1 | Write-allowed flag of the loaded entry |
| fill_user | input | 1 | User-accessible flag of the loaded entry |
| flush | input | 1 | Invalidate all entries |
| age_clear | input | 1 | Clear all accessed flags |
| hit | output | 1 | A valid entry matched |
| miss | output | 1 | No entry matched |
| fault | output | 1 | Access refused |
| fault_code | output | 2 | 0 none, 1 not present, 2 write to read-only, 3 user to supervisor page |
| pa | output | 32 | Physical address, 0 unless the access succeeds |
| set_accessed | output | 1 | Request to mark the page accessed |
| set_dirty | output | 1 | Request to mark the page dirty |
| hit_accessed | output | 1 | Accessed flag of the matched entry before this access |
| hit_dirty | output | 1 | Dirty flag of the matched entry before this access |

## Verification
Several properties are checked on every cycle: the exclusivity of hit and miss, and the silence of all outputs when there is no lookup. The checks also cover the link between `fault` and its code, a miss never faulting, and the page offset passing through on success. Further per-cycle checks are that dirty requests come only with writes and accessed requests, and that nothing hits in the cycle after a flush. The bench alone can show the values that depend on stored state: the fault priority across every flag combination, flags persisting after an access or ageing, and the choice of victim slot under refill. These need a history of refills and lookups to set up.

// File: rtl/tlb_perm.sv
module tlb_perm #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PID_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic                  lk_write,
  input  logic                  lk_user,
  input  logic [PID_W-1:0]      cur_pid,
  input  logic                  fill_en,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PID_W-1:0]      fill_pid,
  input  logic [PA_W-OFF_W-1:0] fill_pfn,
  input  logic                  fill_present,
  input  logic                  fill_writable,
  input  logic                  fill_user,
  input  logic                  flush,
  input  logic                  age_clear,
  output logic                  hit,
  output logic                  miss,
  output logic                  fault,
  output logic [1:0]            fault_code,
  output logic [PA_W-1:0]       pa,
  output logic                  set_accessed,
  output logic                  set_dirty,
  output logic                  hit_accessed,
  output logic                  hit_dirty
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] e_vld, e_p, e_w, e_u, e_a, e_d;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PID_W-1:0]   e_pid [ENTRIES];
  logic [PFN_W-1:0]   e_pfn [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  logic [VPN_W-1:0] vpn;
  logic             hit_any, free_any, ok;
  logic [IDX_W-1:0] hidx, fidx, victim;
  logic [1:0]       code;

  assign vpn = lk_vaddr[VA_W-1:OFF_W];

  always_comb begin
    hit_any  = 1'b0;
    hidx     = '0;
    free_any = 1'b0;
    fidx     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit_any && e_vld[i] && e_vpn[i] == vpn && e_pid[i] == cur_pid) begin
        hit_any = 1'b1;
        hidx    = IDX_W'(i);
      end
      if (!free_any && !e_vld[i]) begin
        free_any = 1'b1;
        fidx     = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (!e_p[hidx])                 code = 2'd1;
    else if (lk_user && !e_u[hidx]) code = 2'd3;
    else if (lk_write && !e_w[hidx]) code = 2'd2;
    else                            code = 2'd0;
  end

  assign hit          = lk_valid & hit_any;
  assign miss         = lk_valid & ~hit_any;
  assign fault_code   = hit ? code : 2'd0;
  assign fault        = fault_code != 2'd0;
  assign ok           = hit & ~fault;
  assign pa           = ok ? {e_pfn[hidx], lk_vaddr[OFF_W-1:0]} : '0;
  assign set_accessed = ok;
  assign set_dirty    = ok & lk_write;
  assign hit_accessed = hit & e_a[hidx];
  assign hit_dirty    = hit & e_d[hidx];
  assign victim       = free_any ? fidx : rr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_a    <= '0;
      e_d    <= '0;
      rr_ptr <= '0;
    end else if (flush) begin
      e_vld  <= '0;
      rr_ptr <= '0;
    end else begin
      if (age_clear) e_a <= '0;
      if (ok) begin
        e_a[hidx] <= 1'b1;
        if (lk_write) e_d[hidx] <= 1'b1;
      end
      if (fill_en) begin
        e_vld[victim] <= 1'b1;
        e_vpn[victim] <= fill_vpn;
        e_pid[victim] <= fill_pid;
        e_pfn[victim] <= fill_pfn;
        e_p[victim]   <= fill_present;
        e_w[victim]   <= fill_writable;
        e_u[victim]   <= fill_user;
        e_a[victim]   <= 1'b0;
        e_d[victim]   <= 1'b0;
        if (!free_any) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
      end
    end
  end
endmodule

module tlb_perm_chk #(
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_write,
  input logic [OFF_W-1:0] va_off,
  input logic [OFF_W-1:0] pa_off,
  input logic             flush,
  input logic             hit,
  input logic             miss,
  input logic             fault,
  input logic [1:0]       fault_code,
  input logic             set_accessed,
  input logic             set_dirty
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(hit && miss)); // R2
  AST_MISS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) miss |-> (!fault && fault_code == 2'd0)); // R2
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n) fault == (fault_code != 2'd0)); // R5
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n) (hit && !fault) |-> pa_off == va_off); // R1
  AST_DIRTY_REQ: assert property (@(posedge clk) disable iff (!rst_n) set_dirty |-> (set_accessed && lk_write)); // R6
  AST_FAULT_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n) fault |-> (!set_accessed && !set_dirty)); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !hit); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |-> !(hit || miss || fault || set_accessed || set_dirty)); // R10
endmodule

bind tlb_perm tlb_perm_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
  .va_off(lk_vaddr[OFF_W-1:0]), .pa_off(pa[OFF_W-1:0]), .flush(flush),
  .hit(hit), .miss(miss), .fault(fault), .fault_code(fault_code),
  .set_accessed(set_accessed), .set_dirty(set_dirty)
);

// File: tb/sim_tlb_perm.sv
module sim_tlb_perm;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [31:0] lk_vaddr = '0;
  logic [3:0]  cur_pid = '0;
  logic fill_en = 0, fill_present = 0, fill_writable = 0, fill_user = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [3:0]  fill_pid = '0;
  logic flush = 0, age_clear = 0;
  logic hit, miss, fault, set_accessed, set_dirty, hit_accessed, hit_dirty;
  logic [1:0]  fault_code;
  logic [31:0] pa;

  int checks = 0;
  int fails = 0;

  tlb_perm u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_user(lk_user), .cur_pid(cur_pid),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_pfn(fill_pfn),
    .fill_present(fill_present), .fill_writable(fill_writable), .fill_user(fill_user),
    .flush(flush), .age_clear(age_clear), .hit(hit), .miss(miss), .fault(fault),
    .fault_code(fault_code), .pa(pa), .set_accessed(set_accessed), .set_dirty(set_dirty),
    .hit_accessed(hit_accessed), .hit_dirty(hit_dirty)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [3:0] pid, input logic [19:0] pfn,
                      input logic p, input logic w, input logic u);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_pid = pid; fill_pfn = pfn;
    fill_present = p; fill_writable = w; fill_user = u;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [3:0] pid, input logic w, input logic u);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; cur_pid = pid; lk_write = w; lk_user = u;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 0; lk_write = 0; lk_user = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state: empty buffer misses
    look(32'h0004_0123, 4'd1, 0, 0);
    check("R2 reset miss", {31'd0, miss}, 32'd1);
    check("R2 reset hit", {31'd0, hit}, 32'd0);
    idle(); #1;
    check("R10 idle outputs", {27'd0, hit, miss, fault, set_accessed, set_dirty}, 32'd0);

    for (int i = 0; i < 8; i++)
      fill(20'h40 + 20'(i), 4'd1, 20'h100 + 20'(i), i != 6, i[0], i[1]);

    for (int i = 0; i < 8; i++)
      for (int w = 0; w < 2; w++)
        for (int u = 0; u < 2; u++) begin
          logic [31:0] va;
          logic [1:0] ec;
          logic p, wr, us;
          p = (i != 6); wr = i[0]; us = i[1];
          va = {20'h40 + 20'(i), 12'((i * 32'h111) & 32'hfff)};
          if (!p) ec = 2'd1;                       // R3
          else if (u[0] && !us) ec = 2'd3;         // R4
          else if (w[0] && !wr) ec = 2'd2;         // R5
          else ec = 2'd0;
          look(va, 4'd1, w[0], u[0]);
          check("R1 hit", {31'd0, hit}, 32'd1);
          check("R3/R4/R5 code", {30'd0, fault_code}, {30'd0, ec});
          check("R5 fault flag", {31'd0, fault}, {31'd0, ec != 2'd0});
          check("R1 pa", pa, (ec == 2'd0) ? {20'h100 + 20'(i), va[11:0]} : 32'd0);
          check("R6 set_accessed", {31'd0, set_accessed}, {31'd0, ec == 2'd0});
          check("R6 set_dirty", {31'd0, set_dirty}, {31'd0, ec == 2'd0 && w[0]});
        end

    // R2 wrong process ID misses
    look(32'h0004_1abc, 4'd2, 0, 0);
    check("R2 pid miss", {30'd0, hit, miss}, 32'd1);
    check("R2 pid pa", pa, 32'd0);
    check("R2 pid fault", {31'd0, fault}, 32'd0);

    // R6 recorded flags
    look(32'h0004_1000, 4'd1, 0, 0);
    check("R6 dirty recorded", {31'd0, hit_dirty}, 32'd1);
    check("R6 accessed recorded", {31'd0, hit_accessed}, 32'd1);
    look(32'h0004_0000, 4'd1, 0, 0);
    check("R6 faulting writes leave clean", {31'd0, hit_dirty}, 32'd0);
    look(32'h0004_6000, 4'd1, 0, 0);
    check("R6 not-present never accessed", {31'd0, hit_accessed}, 32'd0);

    // R7 ageing
    idle();
    @(negedge clk); age_clear = 1;
    @(negedge clk); age_clear = 0;
    look(32'h0004_3000, 4'd1, 0, 0);
    check("R7 accessed cleared", {31'd0, hit_accessed}, 32'd0);
    check("R7 dirty kept", {31'd0, hit_dirty}, 32'd1);
    look(32'h0004_3000, 4'd1, 0, 0);
    check("R7 accessed set again", {31'd0, hit_accessed}, 32'd1);
    idle();

    // R9 round-robin eviction when full
    fill(20'h80, 4'd1, 20'h200, 1, 1, 1);
    look(32'h0004_0000, 4'd1, 0, 0);
    check("R9 slot0 evicted", {31'd0, miss}, 32'd1);
    look(32'h0008_0345, 4'd1, 0, 1);
    check("R9 new entry pa", pa, 32'h0020_0345);
    check("R9 new entry clean", {30'd0, hit_accessed, hit_dirty}, 32'd0);
    idle();
    fill(20'h81, 4'd1, 20'h201, 1, 1, 1);
    look(32'h0004_1000, 4'd1, 0, 0);
    check("R9 slot1 evicted", {31'd0, miss}, 32'd1);
    look(32'h0004_2000, 4'd1, 0, 0);
    check("R9 slot2 kept", {31'd0, hit}, 32'd1);
    idle();

    // R8 flush
    pulse_flush();
    look(32'h0008_0000, 4'd1, 0, 0);
    check("R8 flush miss", {31'd0, miss}, 32'd1);
    idle();

    // R8/R9 after flush: free slots first, then victim back at slot 0
    for (int k = 0; k < 8; k++)
      fill(20'h200 + 20'(k), 4'd3, 20'h300 + 20'(k), 1, 1, 1);
    look(32'h0020_7000, 4'd3, 1, 1);
    check("R9 all free slots used", {31'd0, hit}, 32'd1);
    idle();
    fill(20'h3ff, 4'd3, 20'h3ff, 1, 1, 1);
    look(32'h0020_0000, 4'd3, 0, 0);
    check("R8 victim reset to slot0", {31'd0, miss}, 32'd1);
    look(32'h0020_1000, 4'd3, 0, 0);
    check("R8 slot1 kept", {31'd0, hit}, 32'd1);
    idle(); #1;
    check("R10 idle final", {27'd0, hit, miss, fault, set_accessed, set_dirty}, 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule